// File: doc/BRIEF.md
# Transmit Holding Empty Interrupt Generator

This block raises the "transmit holding register empty" interrupt for a UART transmitter running in FIFO mode. It watches the occupancy count of the transmit FIFO and decides when the holding-empty status may be shown to software. When the FIFO drains after holding two or more bytes at once, the status shows up immediately. When the FIFO has never held more than one byte since the last empty event, the status is held back by one character time less the final stop bit. This keeps software from refilling while the last byte is still being shifted out.

The status drives a latched interrupt request. A write to the holding register clears the request, and so does a read of the interrupt identification register. The interrupt-enable bit masks only the outgoing request. The first interrupt after the FIFO is switched on is never delayed. The interrupt priority encoder outside this block reports the request with identification code 2, at the same priority as the ordinary holding-empty source. A parameter chooses how the hold-back window is measured. It can be a down-counter of bit-clock ticks (the default), or it can follow the serializer's final-stop-bit phase indication.

Top module: `thre_irq_gen`

## Requirements
- R1: While reset is asserted and on the first cycle after it, `thre_status` and `thre_irq` are 0.
- R2: On the first clock edge where `fifo_en` is 1 after having been 0, if `fifo_count` is 0, `thre_status` and the latched request are set at that edge, with no delay.
- R3: If `fifo_count` was 2 or more at any edge since `thre_status` last rose (or since `fifo_en` last went high), then the first edge that samples `fifo_count` as 0 after a nonzero value sets `thre_status` and the request at that same edge.
- R4: Otherwise, that edge loads a delay of L = `char_ticks` − `stop_ticks` (floored at 0). Each later edge with `tick` = 1 lowers the delay by one. `thre_status` and the request are set on the edge that follows the one where the delay reaches 0. With `tick` held at 1, this is L+1 edges after the empty edge, and 1 edge after it when L = 0.
- R5: An edge with `tick` = 0 does not lower a pending delay.
- R6: A nonzero `fifo_count` sampled while a delay is pending cancels it. The next empty event starts a full new delay.
- R7: `thre_status` is 0 after any edge that samples `fifo_count` nonzero.
- R8: An edge with `thr_wr` or `iir_rd` at 1 clears the latched request. The clear wins over a same-edge set, and `iir_rd` leaves `thre_status` unchanged.
- R9: `thre_irq` is the latched request gated by `tx_ie`. A request latched while `tx_ie` = 0 appears as soon as `tx_ie` returns to 1.
- R10: An edge with `fifo_en` = 0 clears `thre_status`, the request, the two-byte history and any pending delay.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| fifo_count | input | CNT_W | Current transmit FIFO occupancy |
| thr_wr | input | 1 | Strobe: software writes the holding register |
| iir_rd | input | 1 | Strobe: software reads the interrupt identification register |
| fifo_en | input | 1 | FIFO mode enable |
| tx_ie | input | 1 | Transmit interrupt enable |
| tick | input | 1 | Bit clock enable, one pulse per bit-clock tick |
| stop_phase | input | 1 | Serializer is in the final stop bit (used when EXPIRE_SRC selects it) |
| char_ticks | input | DLY_W | Character length in ticks |
| stop_ticks | input | DLY_W | Length of the final stop bit in ticks |
| thre_status | output | 1 | Holding-empty status |
| thre_irq | output | 1 | Holding-empty interrupt request |

## Verification
The assertions assume that `fifo_count` only rises from zero in the same cycle as a `thr_wr` strobe, as a real FIFO does. They also assume `fifo_en` stays low throughout reset. The stimulus table and the directed tests respect both rules: every step that raises the count also carries the write strobe, and enable is applied only after reset is released. `char_ticks` and `stop_ticks` change only while no delay is pending.

// File: rtl/thre_pkg.sv
package thre_pkg;

   typedef enum logic {
      SRC_TICK_COUNT = 1'b0,
      SRC_STOP_PHASE = 1'b1
   } expire_src_e;

   function automatic logic [15:0] sat_diff(input logic [15:0] a, input logic [15:0] b);
      return (a > b) ? (a - b) : 16'd0;
   endfunction

endpackage

// File: rtl/thre_occupancy.sv
module thre_occupancy #(
   parameter int CNT_W = 5
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [CNT_W-1:0] fifo_count,
   input  logic             fifo_en,
   input  logic             status_set,
   output logic             empty,
   output logic             empty_rise,
   output logic             en_rise,
   output logic             multi_seen
);

   localparam logic [CNT_W-1:0] TWO = CNT_W'(2);

   logic empty_q;
   logic en_q;
   logic multi_q;

   assign empty      = (fifo_count == '0);
   assign empty_rise = fifo_en & empty & ~empty_q;
   assign en_rise    = fifo_en & ~en_q;
   assign multi_seen = multi_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         empty_q <= 1'b1;
         en_q    <= 1'b0;
      end else begin
         empty_q <= empty;
         en_q    <= fifo_en;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         multi_q <= 1'b0;
      end else if (!fifo_en) begin
         multi_q <= 1'b0;
      end else if (fifo_count >= TWO) begin
         multi_q <= 1'b1;
      end else if (status_set) begin
         multi_q <= 1'b0;
      end
   end

endmodule

// File: rtl/thre_delay.sv
module thre_delay
   import thre_pkg::*;
#(
   parameter int          DLY_W      = 8,
   parameter expire_src_e EXPIRE_SRC = SRC_TICK_COUNT
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             fifo_en,
   input  logic             start,
   input  logic             empty,
   input  logic             tick,
   input  logic             stop_phase,
   input  logic [DLY_W-1:0] load_val,
   output logic             expire
);

   logic pending_q;

   generate
      if (EXPIRE_SRC == SRC_TICK_COUNT) begin : g_count
         logic [DLY_W-1:0] cnt_q;
         logic             done;
         logic             unused_stop;

         assign unused_stop = stop_phase;
         assign done        = pending_q & (cnt_q == '0);
         assign expire      = done & empty;

         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               pending_q <= 1'b0;
               cnt_q     <= '0;
            end else if (!fifo_en) begin
               pending_q <= 1'b0;
               cnt_q     <= '0;
            end else if (start) begin
               pending_q <= 1'b1;
               cnt_q     <= load_val;
            end else if (pending_q && !empty) begin
               pending_q <= 1'b0;
            end else if (done) begin
               pending_q <= 1'b0;
            end else if (pending_q && tick) begin
               cnt_q     <= cnt_q - 1'b1;
            end
         end
      end else begin : g_phase
         logic stop_q;
         logic stop_edge;
         logic unused_cnt;

         assign unused_cnt = ^{tick, load_val};
         assign stop_edge  = stop_phase & ~stop_q;
         assign expire     = pending_q & stop_edge & empty;

         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               stop_q <= 1'b0;
            end else begin
               stop_q <= stop_phase;
            end
         end

         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               pending_q <= 1'b0;
            end else if (!fifo_en) begin
               pending_q <= 1'b0;
            end else if (start) begin
               pending_q <= 1'b1;
            end else if (pending_q && (!empty || stop_edge)) begin
               pending_q <= 1'b0;
            end
         end
      end
   endgenerate

endmodule

// File: rtl/thre_req.sv
module thre_req (
   input  logic clk,
   input  logic rst_n,
   input  logic fifo_en,
   input  logic empty,
   input  logic status_set,
   input  logic thr_wr,
   input  logic iir_rd,
   input  logic tx_ie,
   output logic thre_status,
   output logic thre_irq
);

   logic status_q;
   logic req_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         status_q <= 1'b0;
      end else if (!fifo_en || !empty) begin
         status_q <= 1'b0;
      end else if (status_set) begin
         status_q <= 1'b1;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         req_q <= 1'b0;
      end else if (!fifo_en || thr_wr || iir_rd) begin
         req_q <= 1'b0;
      end else if (status_set) begin
         req_q <= 1'b1;
      end
   end

   assign thre_status = status_q;
   assign thre_irq    = req_q & tx_ie;

endmodule

// File: rtl/thre_irq_gen.sv
module thre_irq_gen
   import thre_pkg::*;
#(
   parameter int          CNT_W      = 5,
   parameter int          DLY_W      = 8,
   parameter expire_src_e EXPIRE_SRC = SRC_TICK_COUNT
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [CNT_W-1:0] fifo_count,
   input  logic             thr_wr,
   input  logic             iir_rd,
   input  logic             fifo_en,
   input  logic             tx_ie,
   input  logic             tick,
   input  logic             stop_phase,
   input  logic [DLY_W-1:0] char_ticks,
   input  logic [DLY_W-1:0] stop_ticks,
   output logic             thre_status,
   output logic             thre_irq
);

   localparam int DIFF_W = 16;

   if (CNT_W < 2) begin : g_bad_cnt
      $error("thre_irq_gen: CNT_W must be at least 2");
   end
   if (DLY_W < 1 || DLY_W > DIFF_W) begin : g_bad_dly
      $error("thre_irq_gen: DLY_W must be within 1..16");
   end

   logic             empty;
   logic             empty_rise;
   logic             en_rise;
   logic             multi_seen;
   logic             expire;
   logic             immediate;
   logic             start_dly;
   logic             status_set;
   logic [DLY_W-1:0] load_val;

   assign load_val   = DLY_W'(sat_diff(DIFF_W'(char_ticks), DIFF_W'(stop_ticks)));
   assign immediate  = (en_rise & empty) | (empty_rise & multi_seen);
   assign start_dly  = empty_rise & ~multi_seen & ~en_rise;
   assign status_set = immediate | expire;

   thre_occupancy #(.CNT_W(CNT_W)) u_occ (
      .clk        (clk),
      .rst_n      (rst_n),
      .fifo_count (fifo_count),
      .fifo_en    (fifo_en),
      .status_set (status_set),
      .empty      (empty),
      .empty_rise (empty_rise),
      .en_rise    (en_rise),
      .multi_seen (multi_seen)
   );

   thre_delay #(.DLY_W(DLY_W), .EXPIRE_SRC(EXPIRE_SRC)) u_dly (
      .clk        (clk),
      .rst_n      (rst_n),
      .fifo_en    (fifo_en),
      .start      (start_dly),
      .empty      (empty),
      .tick       (tick),
      .stop_phase (stop_phase),
      .load_val   (load_val),
      .expire     (expire)
   );

   thre_req u_req (
      .clk         (clk),
      .rst_n       (rst_n),
      .fifo_en     (fifo_en),
      .empty       (empty),
      .status_set  (status_set),
      .thr_wr      (thr_wr),
      .iir_rd      (iir_rd),
      .tx_ie       (tx_ie),
      .thre_status (thre_status),
      .thre_irq    (thre_irq)
   );

endmodule

// File: rtl/thre_irq_gen_chk.sv
module thre_irq_gen_chk #(
   parameter int CNT_W = 5
) (
   input logic             clk,
   input logic             rst_n,
   input logic [CNT_W-1:0] fifo_count,
   input logic             thr_wr,
   input logic             iir_rd,
   input logic             fifo_en,
   input logic             thre_status,
   input logic             thre_irq
);

   p_clear_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (thr_wr || iir_rd) |=> !thre_irq);

   p_busy_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (fifo_count != '0) |=> !thre_status);

   p_off_r10: assert property (@(posedge clk) disable iff (!rst_n)
      !fifo_en |=> (!thre_status && !thre_irq));

   p_enable_r2: assert property (@(posedge clk) disable iff (!rst_n)
      ($rose(fifo_en) && fifo_count == '0) |-> ##1 thre_status);

   p_rise_empty_r4: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(thre_status) |-> ($past(fifo_count) == '0));

endmodule

bind thre_irq_gen thre_irq_gen_chk #(.CNT_W(CNT_W)) u_chk (.*);

// File: tb/thre_irq_gen_bench.sv
module thre_irq_gen_bench;

   localparam int CNT_W = 5;
   localparam int DLY_W = 8;
   localparam int NVEC  = 30;

   // row layout: {count[2:0], thr_wr, iir_rd, fifo_en, tx_ie, tick, exp_status, exp_irq, req[3:0]}
   localparam logic [13:0] VEC [NVEC] = '{
      14'b000_0_0_1_1_1_1_1_0010, // R2 enable while empty
      14'b000_0_1_1_1_1_1_0_1000, // R8 iir read clears request only
      14'b001_1_0_1_1_1_0_0_0111, // R7 one byte written
      14'b000_0_0_1_1_1_0_0_0100, // R4 delay start, L=3
      14'b000_0_0_1_1_1_0_0_0100,
      14'b000_0_0_1_1_1_0_0_0100,
      14'b000_0_0_1_1_1_0_0_0100, // R4 counter reaches zero
      14'b000_0_0_1_1_1_1_1_0100, // R4 expiry
      14'b001_1_0_1_1_1_0_0_1000, // R8 write clears
      14'b010_1_0_1_1_1_0_0_0011, // R3 two bytes held
      14'b001_0_0_1_1_1_0_0_0011,
      14'b000_0_0_1_1_1_1_1_0011, // R3 immediate
      14'b001_1_0_1_1_1_0_0_0111,
      14'b000_0_0_1_1_1_0_0_0110, // R6 delay start (history cleared)
      14'b000_0_0_1_1_1_0_0_0110,
      14'b001_1_0_1_1_1_0_0_0110, // R6 cancel
      14'b001_0_0_1_1_1_0_0_0110,
      14'b001_0_0_1_1_1_0_0_0110,
      14'b000_0_0_1_1_0_0_0_0110, // R6 fresh delay start
      14'b000_0_0_1_1_0_0_0_0101, // R5 no tick
      14'b000_0_0_1_1_0_0_0_0101, // R5 no tick
      14'b000_0_0_1_1_1_0_0_0101,
      14'b000_0_0_1_1_1_0_0_0101,
      14'b000_0_0_1_1_1_0_0_0101,
      14'b000_0_0_1_1_1_1_1_0101, // R5 expiry after stall
      14'b000_0_0_1_0_1_1_0_1001, // R9 masked
      14'b000_0_0_1_1_1_1_1_1001, // R9 unmasked shows latched request
      14'b000_0_0_0_1_1_0_0_1010, // R10 disable clears
      14'b000_0_0_0_1_1_0_0_1010,
      14'b000_0_0_1_1_1_1_1_0010  // R2 re-enable immediate
   };

   logic             clk = 1'b0;
   logic             rst_n = 1'b0;
   logic [CNT_W-1:0] fifo_count = '0;
   logic             thr_wr = 1'b0;
   logic             iir_rd = 1'b0;
   logic             fifo_en = 1'b0;
   logic             tx_ie = 1'b0;
   logic             tick = 1'b0;
   logic             stop_phase = 1'b0;
   logic [DLY_W-1:0] char_ticks = 8'd4;
   logic [DLY_W-1:0] stop_ticks = 8'd1;
   logic             thre_status;
   logic             thre_irq;

   int checks = 0;
   int failures = 0;
   bit done = 1'b0;

   always #4 clk = ~clk;

   thre_irq_gen #(.CNT_W(CNT_W), .DLY_W(DLY_W)) u_thre_irq_gen (
      .clk        (clk),
      .rst_n      (rst_n),
      .fifo_count (fifo_count),
      .thr_wr     (thr_wr),
      .iir_rd     (iir_rd),
      .fifo_en    (fifo_en),
      .tx_ie      (tx_ie),
      .tick       (tick),
      .stop_phase (stop_phase),
      .char_ticks (char_ticks),
      .stop_ticks (stop_ticks),
      .thre_status(thre_status),
      .thre_irq   (thre_irq)
   );

   task automatic check(input string tag, input logic st, input logic irq);
      checks++;
      if (thre_status !== st || thre_irq !== irq) begin
         failures++;
         $display("FAIL %s: status=%b irq=%b expected status=%b irq=%b",
                  tag, thre_status, thre_irq, st, irq);
      end
   endtask

   task automatic drive(input int cnt, input logic wr, input logic rd,
                        input logic en, input logic ie, input logic tk);
      fifo_count = CNT_W'(cnt);
      thr_wr     = wr;
      iir_rd     = rd;
      fifo_en    = en;
      tx_ie      = ie;
      tick       = tk;
      @(posedge clk);
      #1;
   endtask

   initial begin
      repeat (3) @(posedge clk);
      #1;
      check("R1 in reset", 1'b0, 1'b0);
      rst_n = 1'b1;
      @(posedge clk);
      #1;
      check("R1 after reset", 1'b0, 1'b0);

      for (int i = 0; i < NVEC; i++) begin
         logic [13:0] v;
         string tag;
         v = VEC[i];
         drive(int'(v[13:11]), v[10], v[9], v[8], v[7], v[6]);
         tag = $sformatf("row %0d R%0d", i, int'(v[3:0]));
         check(tag, v[5], v[4]);
      end

      // R4 boundary: zero-length hold-back
      char_ticks = 8'd2;
      stop_ticks = 8'd2;
      drive(1, 1'b1, 1'b0, 1'b1, 1'b1, 1'b0);
      check("R4 zero delay write", 1'b0, 1'b0);
      drive(0, 1'b0, 1'b0, 1'b1, 1'b1, 1'b0);
      check("R4 zero delay start", 1'b0, 1'b0);
      drive(0, 1'b0, 1'b0, 1'b1, 1'b1, 1'b0);
      check("R4 zero delay expiry", 1'b1, 1'b1);

      // R8 priority: identification read on the set edge wins
      drive(1, 1'b1, 1'b0, 1'b1, 1'b1, 1'b1);
      drive(2, 1'b1, 1'b0, 1'b1, 1'b1, 1'b1);
      drive(1, 1'b0, 1'b0, 1'b1, 1'b1, 1'b1);
      check("R3 still busy", 1'b0, 1'b0);
      drive(0, 1'b0, 1'b1, 1'b1, 1'b1, 1'b1);
      check("R8 clear beats set", 1'b1, 1'b0);
      drive(0, 1'b0, 1'b0, 1'b1, 1'b1, 1'b1);
      check("R8 stays cleared", 1'b1, 1'b0);

      // R4 saturating load: stop longer than character
      char_ticks = 8'd1;
      stop_ticks = 8'd5;
      drive(1, 1'b1, 1'b0, 1'b1, 1'b1, 1'b1);
      drive(0, 1'b0, 1'b0, 1'b1, 1'b1, 1'b1);
      check("R4 saturated start", 1'b0, 1'b0);
      drive(0, 1'b0, 1'b0, 1'b1, 1'b1, 1'b1);
      check("R4 saturated expiry", 1'b1, 1'b1);

      done = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end

   initial begin
      repeat (20000) @(posedge clk);
      if (!done) begin
         checks++;
         failures++;
         $display("FAIL watchdog expired");
         $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
         $finish;
      end
   end

endmodule